// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterised set of external interrupt lines and presents them to several processor contexts. Every line can be configured through a 32-bit register bus. A line senses either its level or its edges. Its active polarity can be selected, and it can latch on both edges. Each line also has an enable (mask) bit and a pending bit. Software enables and disables lines through separate write-one-to-set and write-one-to-clear words, so no read-modify-write cycle is needed. A single injection register lets software set or clear the pending latch of any edge-mode line. This gives a software-raised interrupt, and it is also how an edge interrupt is acknowledged.

Each line is steered to exactly one context. A context raises its request output while at least one line is pending, enabled and steered to it. A per-context result register reports the lowest-numbered such line, together with a valid flag. A read-only configuration word tells software how many lines and contexts the instance was built with.

Reads are combinational on the address; writes take effect on the clock edge where the write strobe is high. Lines are grouped 32 per word in every per-line bit array: line i lives in word i/32 at bit i%32.

Top module: `shirq_ctrl`

## Requirements
- R1: The word at byte address 0x000 reads the line-group field in bits [23:16] and the context field in bits [7:0]. The line count is (line-group field + 1) × 8 and the context count is (context field + 1). Writes to this word change nothing.
- R2: Writing word w at 0x300+4w enables each line whose data bit is 1. Writing word w at 0x380+4w disables each line whose data bit is 1. Data bits that are 0 leave their lines as they were. The enable state reads back at 0x280+4w, using the same packing as the polarity (0x100), trigger (0x180), dual-edge (0x200) and pending (0x400) arrays.
- R3: A line whose trigger bit is 0 is in level mode, and its pending bit follows the input after two synchronising flops. With polarity bit 1 the line is pending while the input is high; with polarity bit 0 it is pending while the input is low.
- R4: A line whose trigger bit is 1 is in edge mode. It latches pending on a rising input edge when its polarity bit is 1, or on a falling edge when its polarity bit is 0. The latch holds after the input returns, and an edge of the opposite direction does not set it.
- R5: An edge-mode line with its dual-edge bit set latches on both rising and falling edges, whatever its polarity bit holds.
- R6: Writing 0x004 with bits [7:0] = line number and bit 31 = 1 sets that line's edge latch; bit 31 = 0 clears it. A line number at or above the line count is ignored, and a level-mode line's pending bit is unaffected.
- R7: After reset all polarity bits are 1, all trigger and dual-edge bits are 0, every line is disabled, every line is steered to context 0, every edge latch is clear and all request outputs are low.
- R8: The steering word of line i is at 0x800+4i, holding the context number in its low bits. A write whose full 32-bit value is not below the context count is ignored, and the old value reads back.
- R9: ctx_irq[c] is high exactly when some line is pending, enabled and steered to context c. It is low whenever every line is disabled.
- R10: The result word of context c at 0xC00+4c reads bit 31 = 1 and bits [7:0] = the lowest-numbered line that is pending, enabled and steered to c, across all words. When no such line exists it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | LINE_GROUPS*8 | Asynchronous interrupt source lines |
| ctx_irq | output | NUM_CTX | One interrupt request per context |

## Verification
The hardest situation to reach is one where the priority result must be taken from the lowest line across different words of the bit arrays. In that case several lines are pending at once, in mixed sense modes, and steered to different contexts. The stimulus first latches edges on three lines in the second word: one line rising-only, one falling-only and one dual-edge. It acknowledges and re-arms those latches through the injection register. It then steers one of the three to another context and enables them. Finally it raises a level line in the first word, so that context 0's winner has to move from the second word to the first.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

    localparam int ADDR_W     = 12;
    localparam int LINE_IDX_W = 8;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CFG,
        RG_WEDGE,
        RG_POL,
        RG_TRIG,
        RG_DUAL,
        RG_MSTAT,
        RG_SMASK,
        RG_CMASK,
        RG_PEND,
        RG_ROUTE,
        RG_WIN
    } region_e;

    typedef struct packed {
        region_e                region;
        logic [LINE_IDX_W-1:0]  index;
    } decode_t;

    typedef struct packed {
        logic                   valid;
        logic                   set;
        logic [LINE_IDX_W-1:0]  line;
    } wedge_t;

    // Address map: bit arrays sit in 128-byte windows under 0x400,
    // pending at 0x400, steering words at 0x800, context results at 0xC00.
    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.region = RG_NONE;
        d.index  = '0;
        if (a[1:0] == 2'b00) begin
            if (a[11]) begin
                if (!a[10]) begin
                    d.region = RG_ROUTE;
                    d.index  = a[9:2];
                end else if (a[9:7] == 3'd0) begin
                    d.region = RG_WIN;
                    d.index  = {3'b000, a[6:2]};
                end
            end else if (a[10]) begin
                if (a[9:7] == 3'd0) begin
                    d.region = RG_PEND;
                    d.index  = {3'b000, a[6:2]};
                end
            end else begin
                d.index = {3'b000, a[6:2]};
                case (a[9:7])
                    3'd0: begin
                        if (a[6:2] == 5'd0)      d.region = RG_CFG;
                        else if (a[6:2] == 5'd1) d.region = RG_WEDGE;
                    end
                    3'd2: d.region = RG_POL;
                    3'd3: d.region = RG_TRIG;
                    3'd4: d.region = RG_DUAL;
                    3'd5: d.region = RG_MSTAT;
                    3'd6: d.region = RG_SMASK;
                    default: d.region = RG_CMASK;
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/shirq_lines.sv
module shirq_lines
    import shirq_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] src_in,
    input  logic [NUM_LINES-1:0] pol,
    input  logic [NUM_LINES-1:0] trig,
    input  logic [NUM_LINES-1:0] dual,
    input  wedge_t               wedge,
    output logic [NUM_LINES-1:0] pend
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [1:0] sync_q;
        logic       prev_q;
        logic       latch_q;
        logic       rise, fall, evt, hit_set, hit_clr;

        always_comb begin
            rise    = sync_q[1] & ~prev_q;
            fall    = ~sync_q[1] & prev_q;
            evt     = dual[i] ? (rise | fall) : (pol[i] ? rise : fall);
            hit_set = wedge.valid &&  wedge.set && (wedge.line == LINE_IDX_W'(i));
            hit_clr = wedge.valid && !wedge.set && (wedge.line == LINE_IDX_W'(i));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q  <= 2'b00;
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[0], src_in[i]};
                prev_q <= sync_q[1];
                if (!trig[i])
                    latch_q <= 1'b0;
                else
                    latch_q <= (latch_q & ~hit_clr) | evt | hit_set;
            end
        end

        assign pend[i] = trig[i] ? latch_q : (sync_q[1] ~^ pol[i]);
    end

endmodule

// File: rtl/shirq_arbiter.sv
module shirq_arbiter
    import shirq_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CTX   = 3,
    parameter int CTX_W     = 2
) (
    input  logic [NUM_LINES-1:0]                  pend,
    input  logic [NUM_LINES-1:0]                  mask,
    input  logic [NUM_LINES-1:0][CTX_W-1:0]       route,
    output logic [NUM_CTX-1:0]                    win_valid,
    output logic [NUM_CTX-1:0][LINE_IDX_W-1:0]    win_line
);

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        always_comb begin
            win_valid[c] = 1'b0;
            win_line[c]  = '0;
            // Scan downward so the lowest qualifying line is the last to land.
            for (int i = NUM_LINES - 1; i >= 0; i--) begin
                if (pend[i] && mask[i] && (route[i] == CTX_W'(c))) begin
                    win_valid[c] = 1'b1;
                    win_line[c]  = LINE_IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/shirq_regs.sv
module shirq_regs
    import shirq_pkg::*;
#(
    parameter int LINE_GROUPS = 8,
    parameter int NUM_CTX     = 3,
    parameter int CTX_W       = 2,
    localparam int NUM_LINES  = LINE_GROUPS * 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [31:0]                         wdata,
    output logic [31:0]                         rdata,
    input  logic [NUM_LINES-1:0]                pend,
    input  logic [NUM_CTX-1:0]                  win_valid,
    input  logic [NUM_CTX-1:0][LINE_IDX_W-1:0]  win_line,
    output logic [NUM_LINES-1:0]                pol,
    output logic [NUM_LINES-1:0]                trig,
    output logic [NUM_LINES-1:0]                dual,
    output logic [NUM_LINES-1:0]                mask,
    output logic [NUM_LINES-1:0][CTX_W-1:0]     route,
    output wedge_t                              wedge
);

    decode_t dec;

    always_comb dec = decode_addr(addr);

    always_comb begin
        wedge.valid = wr && (dec.region == RG_WEDGE) && (int'(wdata[7:0]) < NUM_LINES);
        wedge.set   = wdata[31];
        wedge.line  = wdata[7:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol   <= '1;
            trig  <= '0;
            dual  <= '0;
            mask  <= '0;
            route <= '0;
        end else if (wr) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (dec.index == LINE_IDX_W'(i / 32)) begin
                    case (dec.region)
                        RG_POL:   pol[i]  <= wdata[i % 32];
                        RG_TRIG:  trig[i] <= wdata[i % 32];
                        RG_DUAL:  dual[i] <= wdata[i % 32];
                        RG_SMASK: if (wdata[i % 32]) mask[i] <= 1'b1;
                        RG_CMASK: if (wdata[i % 32]) mask[i] <= 1'b0;
                        default: ;
                    endcase
                end
                if ((dec.region == RG_ROUTE) && (dec.index == LINE_IDX_W'(i))
                    && (wdata < 32'(NUM_CTX)))
                    route[i] <= wdata[CTX_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (dec.region)
            RG_CFG: begin
                rdata[23:16] = 8'(LINE_GROUPS - 1);
                rdata[7:0]   = 8'(NUM_CTX - 1);
            end
            RG_ROUTE: begin
                for (int i = 0; i < NUM_LINES; i++)
                    if (dec.index == LINE_IDX_W'(i)) rdata[CTX_W-1:0] = route[i];
            end
            RG_WIN: begin
                for (int c = 0; c < NUM_CTX; c++)
                    if (dec.index == LINE_IDX_W'(c)) begin
                        rdata[31]  = win_valid[c];
                        rdata[7:0] = win_line[c];
                    end
            end
            default: begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (dec.index == LINE_IDX_W'(i / 32)) begin
                        case (dec.region)
                            RG_POL:   rdata[i % 32] = pol[i];
                            RG_TRIG:  rdata[i % 32] = trig[i];
                            RG_DUAL:  rdata[i % 32] = dual[i];
                            RG_MSTAT: rdata[i % 32] = mask[i];
                            RG_PEND:  rdata[i % 32] = pend[i];
                            default: ;
                        endcase
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
    import shirq_pkg::*;
#(
    parameter int LINE_GROUPS = 8,
    parameter int NUM_CTX     = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [LINE_GROUPS*8-1:0] src_in,
    output logic [NUM_CTX-1:0]       ctx_irq
);

    localparam int NUM_LINES = LINE_GROUPS * 8;
    localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

    logic [NUM_LINES-1:0]               pol_q, trig_q, dual_q, mask_q, pend;
    logic [NUM_LINES-1:0][CTX_W-1:0]    route_q;
    logic [NUM_CTX-1:0]                 win_valid;
    logic [NUM_CTX-1:0][LINE_IDX_W-1:0] win_line;
    wedge_t                             wedge;

    shirq_regs #(
        .LINE_GROUPS (LINE_GROUPS),
        .NUM_CTX     (NUM_CTX),
        .CTX_W       (CTX_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .pend      (pend),
        .win_valid (win_valid),
        .win_line  (win_line),
        .pol       (pol_q),
        .trig      (trig_q),
        .dual      (dual_q),
        .mask      (mask_q),
        .route     (route_q),
        .wedge     (wedge)
    );

    shirq_lines #(
        .NUM_LINES (NUM_LINES)
    ) u_lines (
        .clk    (clk),
        .rst    (rst),
        .src_in (src_in),
        .pol    (pol_q),
        .trig   (trig_q),
        .dual   (dual_q),
        .wedge  (wedge),
        .pend   (pend)
    );

    shirq_arbiter #(
        .NUM_LINES (NUM_LINES),
        .NUM_CTX   (NUM_CTX),
        .CTX_W     (CTX_W)
    ) u_arb (
        .pend      (pend),
        .mask      (mask_q),
        .route     (route_q),
        .win_valid (win_valid),
        .win_line  (win_line)
    );

    assign ctx_irq = win_valid;

endmodule

// File: rtl/shirq_ctrl_chk.sv
module shirq_ctrl_chk
    import shirq_pkg::*;
#(
    parameter int LINE_GROUPS = 8,
    parameter int NUM_CTX     = 3,
    localparam int NUM_LINES  = LINE_GROUPS * 8,
    localparam int LOW_W      = (NUM_LINES < 32) ? NUM_LINES : 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_CTX-1:0]   ctx_irq,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] trig_q,
    input logic [NUM_LINES-1:0] pend
);

    AST_CFG_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 12'h000) |-> (bus_rdata == {8'h00, 8'(LINE_GROUPS - 1), 8'h00, 8'(NUM_CTX - 1)})); // R1

    AST_SET_MASK: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h300) |=>
        ((mask_q[LOW_W-1:0] & $past(bus_wdata[LOW_W-1:0])) == $past(bus_wdata[LOW_W-1:0]))); // R2

    AST_CLR_MASK: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h380) |=>
        ((mask_q[LOW_W-1:0] & $past(bus_wdata[LOW_W-1:0])) == '0)); // R2

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> (ctx_irq == '0)); // R9

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0 && ctx_irq == '0)); // R7

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_hold
        AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
            (trig_q[i] && pend[i]
             && !(bus_wr && bus_addr == 12'h004 && !bus_wdata[31] && bus_wdata[7:0] == 8'(i))
             && !(bus_wr && bus_addr[11:7] == 5'd3))
            |=> pend[i]); // R4
    end

endmodule

bind shirq_ctrl shirq_ctrl_chk #(
    .LINE_GROUPS (LINE_GROUPS),
    .NUM_CTX     (NUM_CTX)
) u_chk (.*);

// File: tb/shirq_ctrl_test.sv
`timescale 1ns/1ps
module shirq_ctrl_test;

    localparam int LINE_GROUPS = 8;
    localparam int NUM_CTX     = 3;
    localparam int NUM_LINES   = LINE_GROUPS * 8;

    typedef struct {
        string       tag;
        logic        is_irq;
        logic [11:0] addr;
        logic [31:0] exp;
    } item_t;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 bus_wr;
    logic [11:0]          bus_addr;
    logic [31:0]          bus_wdata;
    logic [31:0]          bus_rdata;
    logic [NUM_LINES-1:0] src_in;
    logic [NUM_CTX-1:0]   ctx_irq;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    item_t sb_q[$];
    item_t m_it;
    logic [31:0] act;

    always #10 clk = ~clk;

    shirq_ctrl #(.LINE_GROUPS(LINE_GROUPS), .NUM_CTX(NUM_CTX)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .ctx_irq(ctx_irq)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] e);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.tag = tag; it.is_irq = 1'b0; it.addr = a; it.exp = e;
        sb_q.push_back(it);
        #5;
    endtask

    task automatic expect_irq(input string tag, input logic [NUM_CTX-1:0] e);
        item_t it;
        @(negedge clk);
        it.tag = tag; it.is_irq = 1'b1; it.addr = '0; it.exp = 32'(e);
        sb_q.push_back(it);
        #5;
    endtask

    task automatic set_src(input int i, input logic v);
        @(negedge clk);
        src_in[i] = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares queued expectations shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            m_it = sb_q.pop_front();
            act  = m_it.is_irq ? 32'(ctx_irq) : bus_rdata;
            checks++;
            if (act !== m_it.exp) begin
                errors++;
                $display("FAIL %s irq=%0b addr=%h actual=%h expected=%h",
                         m_it.tag, m_it.is_irq, m_it.addr, act, m_it.exp);
            end
        end
    end

    initial begin
        #(64'd4000000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src_in = '0;
        wait_cyc(3);
        rst = 1'b0;

        // Reset state
        expect_rd("R1 config", 12'h000, 32'h0007_0002);
        expect_rd("R7 mask w0", 12'h280, 32'h0);
        expect_rd("R7 mask w1", 12'h284, 32'h0);
        expect_rd("R7 pol w1", 12'h104, 32'hFFFF_FFFF);
        expect_rd("R7 trig w0", 12'h180, 32'h0);
        expect_rd("R7 dual w1", 12'h204, 32'h0);
        expect_rd("R7 pend w0", 12'h400, 32'h0);
        expect_rd("R7 route line5", 12'h814, 32'h0);
        expect_rd("R10 empty ctx0", 12'hC00, 32'h0);
        expect_irq("R7 irq low", 3'b000);

        wr(12'h000, 32'hFFFF_FFFF);
        expect_rd("R1 config write ignored", 12'h000, 32'h0007_0002);

        // Level mode, line 3
        set_src(3, 1'b1);
        wait_cyc(3);
        expect_rd("R3 level high pending", 12'h400, 32'h8);
        expect_irq("R9 masked no irq", 3'b000);
        wr(12'h300, 32'h8);
        expect_rd("R2 set mask", 12'h280, 32'h8);
        expect_irq("R9 irq ctx0", 3'b001);
        expect_rd("R10 winner line3", 12'hC00, 32'h8000_0003);
        wr(12'h300, 32'h10);
        wr(12'h380, 32'h10);
        expect_rd("R2 zero bits untouched", 12'h280, 32'h8);
        wr(12'h100, 32'hFFFF_FFF7);
        wait_cyc(3);
        expect_rd("R3 low polarity input high", 12'h400, 32'h0);
        expect_irq("R9 not pending", 3'b000);
        set_src(3, 1'b0);
        wait_cyc(3);
        expect_rd("R3 low polarity input low", 12'h400, 32'h8);
        wr(12'h100, 32'hFFFF_FFFF);
        wait_cyc(3);
        expect_rd("R3 restored", 12'h400, 32'h0);
        wr(12'h380, 32'h8);
        expect_rd("R2 clear mask", 12'h280, 32'h0);

        // Edge modes in word 1: line 40 rising, 41 falling, 42 dual
        wr(12'h184, 32'h700);
        wr(12'h104, ~32'h200);
        wr(12'h204, 32'h400);
        expect_rd("R4 edge idle", 12'h404, 32'h0);
        set_src(40, 1'b1); wait_cyc(4);
        set_src(40, 1'b0); wait_cyc(4);
        expect_rd("R4 rising latched", 12'h404, 32'h100);
        set_src(41, 1'b1); wait_cyc(4);
        expect_rd("R4 falling-select ignores rise", 12'h404, 32'h100);
        set_src(41, 1'b0); wait_cyc(4);
        expect_rd("R4 falling latched", 12'h404, 32'h300);
        set_src(42, 1'b1); wait_cyc(4);
        expect_rd("R5 dual rise", 12'h404, 32'h700);
        wr(12'h004, 32'h0000_002A);
        expect_rd("R6 wedge clear 42", 12'h404, 32'h300);
        set_src(42, 1'b0); wait_cyc(4);
        expect_rd("R5 dual fall", 12'h404, 32'h700);

        // Wedge
        wr(12'h004, 32'h0000_0028);
        expect_rd("R6 wedge clear 40", 12'h404, 32'h600);
        wr(12'h004, 32'h8000_0028);
        expect_rd("R6 wedge set 40", 12'h404, 32'h700);
        wr(12'h004, 32'h8000_0005);
        expect_rd("R6 level line unaffected", 12'h400, 32'h0);
        wr(12'h004, 32'h8000_00C8);
        expect_rd("R6 out of range w0", 12'h400, 32'h0);
        expect_rd("R6 out of range w1", 12'h404, 32'h700);

        // Routing and priority
        wr(12'h8A0, 32'h2);
        expect_rd("R8 route line40", 12'h8A0, 32'h2);
        wr(12'h8A0, 32'h3);
        expect_rd("R8 bad context ignored", 12'h8A0, 32'h2);
        wr(12'h304, 32'h700);
        expect_irq("R9 ctx0 and ctx2", 3'b101);
        expect_rd("R10 ctx2 winner", 12'hC08, 32'h8000_0028);
        expect_rd("R10 ctx0 winner", 12'hC00, 32'h8000_0029);
        expect_rd("R10 ctx1 empty", 12'hC04, 32'h0);
        set_src(3, 1'b1);
        wr(12'h300, 32'h8);
        wait_cyc(3);
        expect_rd("R10 lower word wins", 12'hC00, 32'h8000_0003);
        expect_irq("R9 still ctx0 and ctx2", 3'b101);
        wr(12'h380, 32'hFFFF_FFFF);
        wr(12'h384, 32'hFFFF_FFFF);
        expect_irq("R9 all disabled", 3'b000);
        expect_rd("R2 word1 cleared", 12'h284, 32'h0);

        wait_cyc(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule